// File: doc/BRIEF.md
# Eight-Bit Fast PWM Timer with Two Compare Channels

This block is a free-running up-counter that produces two pulse-width modulated outputs. A 3-bit wave-mode input picks the counting ceiling: either the counter's full range, or the active value of compare channel A. Each channel has a compare value and a 2-bit output mode. The mode decides what happens to its output pin when the counter equals the compare value and when the counter wraps back to zero.

Compare values are written through a simple strobe-and-data port into a holding register. They only become active when the counter wraps, so the duty cycle never changes partway through a period. A sticky overflow flag records each wrap and is cleared by a separate strobe.

When channel A sets the ceiling, its own output can only toggle. That gives a square wave whose frequency follows the A value. Channel B stays free to carry an independent duty cycle within that period.

Top module: `fpt_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, both active and holding compare values, both outputs and the overflow flag become zero.
- R2: With `wave_mode` = 3'b011 the count steps by one each cycle from 0 to 255 and then wraps to 0, a period of 256 cycles.
- R3: With `wave_mode` = 3'b111 the ceiling is the active compare A value: the count runs 0..A and wraps, a period of A+1 cycles.
- R4: With any other `wave_mode` code the count runs 0..255 and both outputs stay low whatever the channel modes are.
- R5: The overflow flag rises on the edge where the count goes from the ceiling to 0. It is seen together with count 0 and stays set until an `ovf_clr` pulse clears it. When a wrap and a clear fall on the same edge, the flag is set.
- R6: Channel mode 2'b10 drives the output high from count 0 through the compare value inclusive and low for the rest of the period. A compare value at or above the ceiling keeps the output high.
- R7: Channel mode 2'b11 is the inverse of 2'b10: the output is low from count 0 through the compare value and high afterwards. A compare value at or above the ceiling keeps it low.
- R8: Channel mode 2'b01 inverts the output on every edge where the count equals the compare value. With `wave_mode` 3'b111 this gives a 50% waveform of period 2(A+1). With A = 0 the output inverts on every clock, which is half the clock frequency.
- R9: Channel mode 2'b00 keeps the output low.
- R10: A compare write lands in a holding register and becomes active only on the next wrap. A write during a period leaves that period's waveform unchanged.
- R11: With `wave_mode` 3'b111, channel B's pulse width follows its own compare value and mode within the period set by A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; the count advances on every rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wave_mode | input | 3 | Ceiling select: 3'b011 full range, 3'b111 compare A, other codes plain counting |
| mode_a | input | 2 | Channel A output mode (00 off, 01 toggle, 10 clear on match, 11 set on match) |
| mode_b | input | 2 | Channel B output mode, same encoding as `mode_a` |
| cmp_a_wr | input | 1 | Write strobe for the channel A holding register |
| cmp_b_wr | input | 1 | Write strobe for the channel B holding register |
| cmp_wdata | input | 8 | Compare value written by either strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest condition to reach is a compare write arriving mid-period while a waveform is already running. Only there does the holding register make any visible difference. The stimulus first lets a known duty cycle settle and then waits until the count reaches a chosen value. It then writes a new compare value and looks at the output just past the old match point, and again at the same point in the following period. A second hard case is a clear strobe landing on the same edge as a wrap. The bench reaches it by timing the strobe to the cycle in which the count shows 255.

// File: rtl/fpt_pkg.sv
// Package: shared encodings for the fast PWM timer.
// Assumes: channel mode and wave mode codes are fixed by the register layout
// that software writes, so their values must not be renumbered.
package fpt_pkg;

    typedef enum logic [1:0] {
        OUT_OFF       = 2'b00,
        OUT_TOGGLE    = 2'b01,
        OUT_CLR_MATCH = 2'b10,
        OUT_SET_MATCH = 2'b11
    } out_mode_e;

    localparam logic [2:0] WAVE_FAST_FULL = 3'b011;
    localparam logic [2:0] WAVE_FAST_CMPA = 3'b111;

endpackage

// File: rtl/fpt_counter.sv
// Module: fpt_counter
// Up-counter with a selectable ceiling and a sticky overflow flag.
// Assumes: top_cmp only changes on the edge where wrap is high, so the count
// never skips past the ceiling in normal use.
module fpt_counter
    import fpt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   wave_mode,
    input  logic [W-1:0] top_cmp,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         pwm_en,
    output logic         ovf_flag
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] top_val;

    // Decode the wave mode into an enable and a ceiling value.
    always_comb begin
        pwm_en  = (wave_mode == WAVE_FAST_FULL) || (wave_mode == WAVE_FAST_CMPA);
        top_val = (wave_mode == WAVE_FAST_CMPA) ? top_cmp : CNT_MAX;
        wrap    = (cnt == top_val);
    end

    // Advance the count, restarting at zero after the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Sticky overflow flag; a wrap wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (wrap)     ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));                                  // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (cnt == W'($past(cnt) + 1'b1)));              // R3
    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);                                     // R5

endmodule

// File: rtl/fpt_cmp_buf.sv
// Module: fpt_cmp_buf
// Two-stage compare value: a holding register that takes writes and an active
// register that loads from it on each wrap.
// Assumes: a write on the wrap edge itself waits for the following wrap.
module fpt_cmp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] active
);

    logic [W-1:0] hold_q;

    // Capture software writes into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (wr_en) hold_q <= wr_data;
    end

    // Move the held value into use at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= hold_q;
    end

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));                             // R10

endmodule

// File: rtl/fpt_wave_out.sv
// Module: fpt_wave_out
// One output channel: applies the channel mode at compare match and at the
// period boundary, and registers the result.
// Assumes: cnt and wrap come from fpt_counter on the same clock. When a match
// and a wrap occur together, the wrap action wins.
module fpt_wave_out
    import fpt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm_en,
    input  logic [1:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         wrap,
    output logic         wave
);

    out_mode_e mode_e;
    logic      match;

    // Name the mode bits and detect the compare match.
    always_comb begin
        mode_e = out_mode_e'(mode);
        match  = (cnt == cmp);
    end

    // Drive the channel output from its mode, the match and the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else if (!pwm_en) begin
            wave <= 1'b0;
        end else begin
            case (mode_e)
                OUT_TOGGLE:    if (match) wave <= ~wave;
                OUT_CLR_MATCH: if (wrap) wave <= 1'b1; else if (match) wave <= 1'b0;
                OUT_SET_MATCH: if (wrap) wave <= 1'b0; else if (match) wave <= 1'b1;
                default:       wave <= 1'b0;
            endcase
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en || mode_e == OUT_OFF) |=> !wave);              // R9
    AST_CLR_SET_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && mode_e == OUT_CLR_MATCH && wrap) |=> wave);  // R6
    AST_SET_CLR_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && mode_e == OUT_SET_MATCH && wrap) |=> !wave); // R7
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && mode_e == OUT_TOGGLE && match) |=> (wave != $past(wave))); // R8

endmodule

// File: rtl/fpt_timer.sv
// Module: fpt_timer
// Top of the fast PWM timer: one counter, and two compare channels built by a
// generate loop, each with its own holding register and output stage.
// Assumes: clk is the timer clock with no prescaling; wave_mode and the channel
// modes are quasi-static configuration.
module fpt_timer
    import fpt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   wave_mode,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    input  logic         cmp_a_wr,
    input  logic         cmp_b_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         ovf_clr,
    output logic [W-1:0] count,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic         ovf_flag
);

    localparam int NUM_CH = 2;

    logic                        wrap;
    logic                        pwm_en;
    logic [NUM_CH-1:0]           ch_wr;
    logic [NUM_CH-1:0][1:0]      ch_mode;
    logic [NUM_CH-1:0][W-1:0]    ch_cmp;
    logic [NUM_CH-1:0]           ch_wave;

    // Gather per-channel controls into arrays; index 0 is channel A.
    always_comb begin
        ch_wr   = {cmp_b_wr, cmp_a_wr};
        ch_mode = {mode_b, mode_a};
        pwm_a   = ch_wave[0];
        pwm_b   = ch_wave[1];
    end

    fpt_counter #(.W(W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .wave_mode (wave_mode),
        .top_cmp   (ch_cmp[0]),
        .flag_clr  (ovf_clr),
        .cnt       (count),
        .wrap      (wrap),
        .pwm_en    (pwm_en),
        .ovf_flag  (ovf_flag)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        fpt_cmp_buf #(.W(W)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_wr[g]),
            .wr_data (cmp_wdata),
            .load    (wrap),
            .active  (ch_cmp[g])
        );

        fpt_wave_out #(.W(W)) u_wave (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwm_en (pwm_en),
            .mode   (ch_mode[g]),
            .cnt    (count),
            .cmp    (ch_cmp[g]),
            .wrap   (wrap),
            .wave   (ch_wave[g])
        );
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !pwm_a && !pwm_b && !ovf_flag)); // R1
    AST_CEIL_CMPA: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == WAVE_FAST_CMPA && count == ch_cmp[0]) |=> (count == '0)); // R3

endmodule

// File: tb/fpt_timer_tb.sv
`timescale 1ns/1ps
module fpt_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] wave_mode = 3'b011;
    logic [1:0] mode_a = 2'b00;
    logic [1:0] mode_b = 2'b00;
    logic       cmp_a_wr = 1'b0;
    logic       cmp_b_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'h00;
    logic       ovf_clr = 1'b0;
    logic [7:0] count;
    logic       pwm_a, pwm_b, ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .mode_a(mode_a),
        .mode_b(mode_b), .cmp_a_wr(cmp_a_wr), .cmp_b_wr(cmp_b_wr),
        .cmp_wdata(cmp_wdata), .ovf_clr(ovf_clr), .count(count),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [2:0] wm;
        logic [1:0] ma;
        logic [1:0] mb;
        logic [7:0] ca;
        logic [7:0] cb;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'b011, 2'b10, 2'b10, 8'h40, 8'hC0},
        '{3'b011, 2'b11, 2'b10, 8'h10, 8'hFF},
        '{3'b111, 2'b01, 2'b10, 8'h09, 8'h03},
        '{3'b111, 2'b01, 2'b11, 8'h00, 8'h05},
        '{3'b111, 2'b00, 2'b10, 8'h31, 8'h31},
        '{3'b011, 2'b10, 2'b11, 8'hFF, 8'h00},
        '{3'b000, 2'b10, 2'b11, 8'h20, 8'h20}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // High cycles over two periods, from the channel-mode requirements.
    function automatic int exp_high(input logic [2:0] wm, input logic [1:0] m,
                                    input int cmp, input int top);
        int p = top + 1;
        if (wm != 3'b011 && wm != 3'b111) return 0;   // R4
        case (m)
            2'b10:   return (cmp >= top) ? 2*p : 2*(cmp+1);   // R6
            2'b11:   return (cmp >= top) ? 0 : 2*(p-cmp-1);   // R7
            2'b01:   return p;                                // R8
            default: return 0;                                // R9
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_a(input logic [7:0] v);
        cmp_wdata = v; cmp_a_wr = 1'b1;
        @(negedge clk);
        cmp_a_wr = 1'b0;
    endtask

    task automatic write_b(input logic [7:0] v);
        cmp_wdata = v; cmp_b_wr = 1'b1;
        @(negedge clk);
        cmp_b_wr = 1'b0;
    endtask

    task automatic wait_cnt(input logic [7:0] v);
        do @(negedge clk); while (count != v);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check(count == 0 && !pwm_a && !pwm_b && !ovf_flag, "R1 reset state",
              {count, pwm_a, pwm_b, ovf_flag}, 0);

        // Vector table: modes, ceilings and compare values per row.
        for (int v = 0; v < NV; v++) begin
            int top, ha, hb, wraps, ea, eb;
            wave_mode = VECS[v].wm; mode_a = VECS[v].ma; mode_b = VECS[v].mb;
            do_reset();
            write_a(VECS[v].ca);
            write_b(VECS[v].cb);
            repeat (600) @(negedge clk);
            top = (VECS[v].wm == 3'b111) ? int'(VECS[v].ca) : 255;
            ha = 0; hb = 0; wraps = 0;
            for (int i = 0; i < 2*(top+1); i++) begin
                @(negedge clk);
                if (pwm_a) ha++;
                if (pwm_b) hb++;
                if (count == 0) wraps++;
            end
            ea = exp_high(VECS[v].wm, VECS[v].ma, int'(VECS[v].ca), top);
            eb = exp_high(VECS[v].wm, VECS[v].mb, int'(VECS[v].cb), top);
            check(wraps == 2, "R2/R3 period length (R2 R3 R4)", wraps, 2);
            check(ha == ea, "R6 R7 R8 R9 channel A duty", ha, ea);
            check(hb == eb, "R11 channel B duty", hb, eb);
        end

        // R8: A = 0 as ceiling, toggle output flips every clock.
        wave_mode = 3'b111; mode_a = 2'b01; mode_b = 2'b00;
        do_reset();
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            logic prev;
            prev = pwm_a;
            @(negedge clk);
            check(pwm_a != prev, "R8 half clock toggle", pwm_a, !prev);
        end

        // R10: mid-period write keeps the current period's waveform.
        wave_mode = 3'b011; mode_a = 2'b10;
        do_reset();
        write_a(8'h40);
        repeat (600) @(negedge clk);
        wait_cnt(8'h10);
        write_a(8'h80);
        wait_cnt(8'h42);
        check(pwm_a == 1'b0, "R10 old compare still active", pwm_a, 0);
        wait_cnt(8'h00);
        wait_cnt(8'h42);
        check(pwm_a == 1'b1, "R10 new compare after wrap", pwm_a, 1);
        wait_cnt(8'h82);
        check(pwm_a == 1'b0, "R10 new compare clears", pwm_a, 0);

        // R5: flag clear, set on wrap, and set winning over clear.
        wait_cnt(8'h80);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(ovf_flag == 1'b0, "R5 flag cleared", ovf_flag, 0);
        wait_cnt(8'hFE);
        check(ovf_flag == 1'b0, "R5 flag stays clear before wrap", ovf_flag, 0);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(count == 8'h00 && ovf_flag == 1'b1, "R5 wrap wins over clear",
              ovf_flag, 1);

        // R1: reset in the middle of activity.
        mode_b = 2'b11;
        write_b(8'h05);
        wait_cnt(8'h30);
        rst_n = 1'b0;
        @(negedge clk);
        check(count == 0 && !pwm_a && !pwm_b && !ovf_flag, "R1 mid-run reset",
              {count, pwm_a, pwm_b, ovf_flag}, 0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        check(pwm_a == 1'b0 || count <= 8'h00, "R1 compare A cleared by reset",
              pwm_a, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule